// File: doc/BRIEF.md
# Source Node Request Filter

This block screens incoming asynchronous requests by the identity of the node that sent them. Each request comes with a 16-bit source ID and a one-cycle valid strobe. One cycle later the block reports two things. The first is whether the request is accepted at all. The second is whether it should go to the physical-request path instead of the ordinary request handling.

Both answers come from two 64-bit bitmaps: an acceptance map and a physical-routing map. When the source sits on this node's own bus, its node number picks one bit of each map. When the source is on another bus, a single override bit at the top of each map decides for every such source. Software edits each map one 32-bit word at a time through set and clear strobes. A bus reset wipes both maps.

The source ID carries the bus number in bits 15:6 and the node number in bits 5:0. A bus number of all ones is treated as the local bus, the same as a bus number equal to the configured local bus ID.

Top module: `source_node_filter`

## Requirements
- R1: After the synchronous reset, both bitmaps are all zero and the decision outputs are low, so every request is rejected until bits are set.
- R2: A request sampled with `req_valid` high produces `dec_valid` high on the next cycle only. `dec_valid` is low in any cycle that does not follow a request. Whenever `dec_valid` is low, `dec_accept` and `dec_phys` are also low.
- R3: A request from local node N (0..62) is accepted only if bit N of the acceptance map is set. Word 0 holds map bits 0..31 and word 1 holds map bits 32..63, with word bit i equal to map bit 32*w+i.
- R4: A source is local when its bus field (bits 15:6) equals `local_bus_id` or equals 10'h3FF. The node field is bits 5:0.
- R5: A request from a non-local source is accepted only if acceptance map bit 63 (word 1, bit 31) is set. The per-node bits play no part in that decision.
- R6: A request from local node N is physical-routed when it is accepted and bit N of the physical map is set.
- R7: A request from a non-local source is physical-routed when it is accepted and physical map bit 63 is set.
- R8: `dec_phys` is never high unless `dec_accept` is high in the same cycle.
- R9: A local source with node number 63 is never accepted, whatever the map contents are.
- R10: A set strobe ORs the data word into the selected map word. A clear strobe clears the bits that are ones in the data word. All other bits keep their value. When both strobes are high together, the clear takes precedence for those bits.
- R11: `bus_reset` clears both bitmaps on the next edge. It takes precedence over any write in the same cycle.
- R12: The decision uses the map contents from before any write made in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Clears both bitmaps |
| req_valid | input | 1 | Request strobe |
| req_src_id | input | 16 | Source ID: bus in 15:6, node in 5:0 |
| local_bus_id | input | 10 | This node's bus number |
| afl_set | input | 1 | Set strobe, acceptance map |
| afl_clr | input | 1 | Clear strobe, acceptance map |
| afl_word | input | 1 | Word select, acceptance map |
| afl_data | input | 32 | Write data, acceptance map |
| pfl_set | input | 1 | Set strobe, physical map |
| pfl_clr | input | 1 | Clear strobe, physical map |
| pfl_word | input | 1 | Word select, physical map |
| pfl_data | input | 32 | Write data, physical map |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Request accepted |
| dec_phys | output | 1 | Request goes to the physical path |

## Verification
The assertions assume that `bus_reset` is low during and just after the synchronous reset. This matters because the bus-reset rule looks back one cycle. The bench raises `bus_reset` only once, well after reset has been released. The assertions also assume that the local bus ID does not change between a request and its decision. The bench sets `local_bus_id` once and never changes it again. Stimulus changes only on falling edges, so every request, write and bus reset is seen as a clean one-cycle event at the next rising edge.

// File: rtl/srcflt_pkg.sv
package srcflt_pkg;
  // Registered verdict handed out one cycle after a request.
  typedef struct packed {
    logic valid;
    logic accept;
    logic phys;
  } verdict_t;
endpackage

// File: rtl/srcflt_map.sv
// Word-addressed bitmap with set/clear write strobes and a bus-reset wipe.
module srcflt_map #(
  parameter int MAP_W  = 64,
  parameter int WORD_W = 32,
  parameter int WSEL_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wipe,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [WSEL_W-1:0] word_sel,
  input  logic [WORD_W-1:0] data,
  output logic [MAP_W-1:0]  map_q
);
  localparam int WORDS = MAP_W / WORD_W;

  logic [WORD_W-1:0] set_mask;
  logic [WORD_W-1:0] clr_mask;

  assign set_mask = set_en ? data : '0;
  assign clr_mask = clr_en ? data : '0;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || wipe) begin
        map_q[w*WORD_W +: WORD_W] <= '0;
      end else if ((set_en || clr_en) && (word_sel == WSEL_W'(w))) begin
        map_q[w*WORD_W +: WORD_W] <= (map_q[w*WORD_W +: WORD_W] | set_mask) & ~clr_mask;
      end
    end
  end
endmodule

// File: rtl/srcflt_decide.sv
// Locality check, bitmap lookup and registered verdict.
module srcflt_decide
  import srcflt_pkg::*;
#(
  parameter int BUS_W  = 10,
  parameter int NODE_W = 6,
  parameter int MAP_W  = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [BUS_W+NODE_W-1:0] req_src_id,
  input  logic [BUS_W-1:0]        local_bus_id,
  input  logic [MAP_W-1:0]        acc_map,
  input  logic [MAP_W-1:0]        phy_map,
  output verdict_t                verdict
);
  localparam int OVR_BIT = MAP_W - 1;

  logic [BUS_W-1:0]  src_bus;
  logic [NODE_W-1:0] src_node;
  logic              is_local;
  logic              node_usable;
  logic              acc_hit;
  logic              phy_hit;

  assign src_bus  = req_src_id[BUS_W+NODE_W-1 -: BUS_W];
  assign src_node = req_src_id[NODE_W-1:0];

  always_comb begin
    is_local    = (src_bus == local_bus_id) || (&src_bus);
    node_usable = ~(&src_node);
    if (is_local) begin
      acc_hit = node_usable & acc_map[src_node];
      phy_hit = acc_hit & phy_map[src_node];
    end else begin
      acc_hit = acc_map[OVR_BIT];
      phy_hit = acc_hit & phy_map[OVR_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict <= '0;
    end else begin
      verdict.valid  <= req_valid;
      verdict.accept <= req_valid & acc_hit;
      verdict.phys   <= req_valid & phy_hit;
    end
  end
endmodule

// File: rtl/source_node_filter.sv
module source_node_filter
  import srcflt_pkg::*;
#(
  parameter int BUS_W  = 10,
  parameter int NODE_W = 6,
  parameter int WORD_W = 32,
  localparam int MAP_W  = 2 ** NODE_W,
  localparam int WSEL_W = $clog2(MAP_W / WORD_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_reset,
  input  logic                    req_valid,
  input  logic [BUS_W+NODE_W-1:0] req_src_id,
  input  logic [BUS_W-1:0]        local_bus_id,
  input  logic                    afl_set,
  input  logic                    afl_clr,
  input  logic [WSEL_W-1:0]       afl_word,
  input  logic [WORD_W-1:0]       afl_data,
  input  logic                    pfl_set,
  input  logic                    pfl_clr,
  input  logic [WSEL_W-1:0]       pfl_word,
  input  logic [WORD_W-1:0]       pfl_data,
  output logic                    dec_valid,
  output logic                    dec_accept,
  output logic                    dec_phys
);
  logic [MAP_W-1:0] acc_map;
  logic [MAP_W-1:0] phy_map;
  verdict_t         verdict;

  srcflt_map #(.MAP_W(MAP_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)) acc_map_i (
    .clk(clk), .rst(rst), .wipe(bus_reset),
    .set_en(afl_set), .clr_en(afl_clr), .word_sel(afl_word), .data(afl_data),
    .map_q(acc_map)
  );

  srcflt_map #(.MAP_W(MAP_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)) phy_map_i (
    .clk(clk), .rst(rst), .wipe(bus_reset),
    .set_en(pfl_set), .clr_en(pfl_clr), .word_sel(pfl_word), .data(pfl_data),
    .map_q(phy_map)
  );

  srcflt_decide #(.BUS_W(BUS_W), .NODE_W(NODE_W), .MAP_W(MAP_W)) decide_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src_id(req_src_id),
    .local_bus_id(local_bus_id), .acc_map(acc_map), .phy_map(phy_map),
    .verdict(verdict)
  );

  assign dec_valid  = verdict.valid;
  assign dec_accept = verdict.accept;
  assign dec_phys   = verdict.phys;
endmodule

// File: rtl/srcflt_chk.sv
module srcflt_chk #(
  parameter int BUS_W  = 10,
  parameter int NODE_W = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_reset,
  input logic                    req_valid,
  input logic [BUS_W+NODE_W-1:0] req_src_id,
  input logic [BUS_W-1:0]        local_bus_id,
  input logic                    dec_valid,
  input logic                    dec_accept,
  input logic                    dec_phys
);
  logic src_local;
  assign src_local = (req_src_id[BUS_W+NODE_W-1 -: BUS_W] == local_bus_id)
                   || (&req_src_id[BUS_W+NODE_W-1 -: BUS_W]);

  // R8
  phys_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
    dec_phys |-> dec_accept);

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid);

  // R2
  idle_outputs_low_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!dec_accept && !dec_phys));

  // R9
  bcast_node_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && src_local && (&req_src_id[NODE_W-1:0])) |=> !dec_accept);

  // R11
  bus_reset_wipes_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(bus_reset)) |=> !dec_accept);
endmodule

bind source_node_filter srcflt_chk #(.BUS_W(BUS_W), .NODE_W(NODE_W)) chk_i (
  .clk(clk), .rst(rst), .bus_reset(bus_reset), .req_valid(req_valid),
  .req_src_id(req_src_id), .local_bus_id(local_bus_id),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_phys(dec_phys)
);

// File: tb/source_node_filter_tb_top.sv
`timescale 1ns/1ps
module source_node_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_reset = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_src_id = '0;
  logic [9:0]  local_bus_id = 10'h012;
  logic        afl_set = 0, afl_clr = 0, pfl_set = 0, pfl_clr = 0;
  logic [0:0]  afl_word = '0, pfl_word = '0;
  logic [31:0] afl_data = '0, pfl_data = '0;
  logic        dec_valid, dec_accept, dec_phys;

  int n_checks = 0;
  int n_fail = 0;

  localparam logic [9:0] LOC   = 10'h012;
  localparam logic [9:0] OTHER = 10'h013;

  always #10 clk = ~clk;

  source_node_filter dut_i (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .req_valid(req_valid),
    .req_src_id(req_src_id), .local_bus_id(local_bus_id),
    .afl_set(afl_set), .afl_clr(afl_clr), .afl_word(afl_word), .afl_data(afl_data),
    .pfl_set(pfl_set), .pfl_clr(pfl_clr), .pfl_word(pfl_word), .pfl_data(pfl_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_phys(dec_phys)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Issue one request and check the verdict one cycle later.
  task automatic ask(input logic [9:0] bus, input logic [5:0] node,
                     input logic exp_acc, input logic exp_phy, input string req);
    @(negedge clk);
    req_valid  = 1'b1;
    req_src_id = {bus, node};
    @(negedge clk);
    req_valid  = 1'b0;
    check({req, " valid"}, dec_valid, 1'b1);
    check({req, " accept"}, dec_accept, exp_acc);
    check({req, " phys"}, dec_phys, exp_phy);
  endtask

  task automatic wr_acc(input logic s, input logic c, input logic w, input logic [31:0] d);
    @(negedge clk);
    afl_set = s; afl_clr = c; afl_word = w; afl_data = d;
    @(negedge clk);
    afl_set = 0; afl_clr = 0;
  endtask

  task automatic wr_phy(input logic s, input logic c, input logic w, input logic [31:0] d);
    @(negedge clk);
    pfl_set = s; pfl_clr = c; pfl_word = w; pfl_data = d;
    @(negedge clk);
    pfl_set = 0; pfl_clr = 0;
  endtask

  task automatic t_reset;
    check("R1 valid after reset", dec_valid, 1'b0);
    check("R1 accept after reset", dec_accept, 1'b0);
    ask(LOC, 6'd5, 1'b0, 1'b0, "R1 empty map");
    ask(OTHER, 6'd5, 1'b0, 1'b0, "R1 empty override");
  endtask

  task automatic t_local;
    wr_acc(1, 0, 1'b0, 32'h0000_0020);          // node 5
    ask(LOC, 6'd5, 1'b1, 1'b0, "R3 node5");
    @(negedge clk);
    check("R2 idle valid low", dec_valid, 1'b0);
    ask(LOC, 6'd6, 1'b0, 1'b0, "R3 node6 clear");
    wr_acc(1, 0, 1'b1, 32'h0000_0100);          // node 40
    ask(LOC, 6'd40, 1'b1, 1'b0, "R3 node40 word1");
    ask(10'h3FF, 6'd5, 1'b1, 1'b0, "R4 all-ones bus local");
    ask(OTHER, 6'd5, 1'b0, 1'b0, "R5 remote without override");
  endtask

  task automatic t_remote;
    wr_acc(1, 0, 1'b1, 32'h8000_0000);          // override bit 63
    ask(OTHER, 6'd7, 1'b1, 1'b0, "R5 remote override");
    ask(LOC, 6'd7, 1'b0, 1'b0, "R5 override not for local");
    wr_phy(1, 0, 1'b1, 32'h8000_0000);
    ask(OTHER, 6'd7, 1'b1, 1'b1, "R7 remote phys");
    ask(LOC, 6'd5, 1'b1, 1'b0, "R7 override not for local phys");
  endtask

  task automatic t_phys;
    wr_phy(1, 0, 1'b0, 32'h0000_0220);          // nodes 5 and 9
    ask(LOC, 6'd5, 1'b1, 1'b1, "R6 local phys");
    ask(LOC, 6'd9, 1'b0, 1'b0, "R8 phys without accept");
  endtask

  task automatic t_bcast;
    wr_acc(1, 0, 1'b1, 32'hFFFF_FFFF);
    wr_phy(1, 0, 1'b1, 32'hFFFF_FFFF);
    ask(LOC, 6'd63, 1'b0, 1'b0, "R9 local node63");
    ask(10'h3FF, 6'd63, 1'b0, 1'b0, "R9 alias node63");
    ask(LOC, 6'd62, 1'b1, 1'b1, "R9 node62 ok");
  endtask

  task automatic t_setclr;
    wr_acc(0, 1, 1'b0, 32'h0000_0020);          // clear node 5
    ask(LOC, 6'd5, 1'b0, 1'b0, "R10 cleared bit");
    ask(LOC, 6'd40, 1'b1, 1'b1, "R10 other bit kept");
    wr_acc(1, 1, 1'b0, 32'h0000_1000);          // node 12, both strobes
    ask(LOC, 6'd12, 1'b0, 1'b0, "R10 clear wins");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    req_valid = 1'b1; req_src_id = {LOC, 6'd20};
    afl_set = 1'b1; afl_word = 1'b0; afl_data = 32'h0010_0000;
    @(negedge clk);
    req_valid = 1'b0; afl_set = 1'b0;
    check("R12 old map used", dec_accept, 1'b0);
    ask(LOC, 6'd20, 1'b1, 1'b0, "R12 new map next");
  endtask

  task automatic t_bus_reset;
    @(negedge clk);
    bus_reset = 1'b1;
    afl_set = 1'b1; afl_word = 1'b0; afl_data = 32'h0000_0008;
    @(negedge clk);
    bus_reset = 1'b0; afl_set = 1'b0;
    ask(LOC, 6'd3, 1'b0, 1'b0, "R11 write lost to bus reset");
    ask(LOC, 6'd40, 1'b0, 1'b0, "R11 map wiped");
    ask(OTHER, 6'd1, 1'b0, 1'b0, "R11 override wiped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_local();
    t_remote();
    t_phys();
    t_bcast();
    t_setclr();
    t_same_cycle();
    t_bus_reset();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule